// File: doc/BRIEF.md
# SMBus Block-Transfer Buffer Sequencer

This block holds the byte buffer and the running index used by an SMBus host for block writes and block reads. Software reaches it through single-cycle register strobes (mode, count, block data port, status, start). The bus engine reaches it through two byte streams: an outgoing stream that carries the bytes of a block write, and an incoming stream that delivers the bytes of a block read.

Two modes are selected by bit 1 of the mode register. In buffered mode software queues the whole message through the block data port, whose index advances on every access, and drains a received block the same way. In byte-at-a-time mode each byte passes through a single holding register, and software moves to the next byte by writing the status register. Block reads in that mode end when the last-byte control flag is set at a status write.

Both streams use valid/ready. The outgoing stream holds `tx_valid`, `tx_data` and `tx_last` unchanged until `tx_ready` is seen at a clock edge, so the engine may stall any beat for any time. The incoming stream is accepted only while a read is in progress (`rx_ready` high), and `rx_last` marks the final byte. During either transfer, software writes to the block data port are not stored.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset the status byte is 0x00, the operation-done flag is 1, the index is 0, `tx_valid` is 0 and `rx_ready` is 0.
- R2: The mode register keeps two bits: bit 1 selects buffered mode and bit 0 is a packet-error-check enable that is only stored and read back.
- R3: In buffered mode a block-port write stores the byte at the index and adds one to the index, and a block-port read returns the byte at the index and adds one; an index equal to the capacity (32) is turned to 0 before the access.
- R4: A buffered write start whose index equals the count streams the bytes at buffer positions 0 to count-1 in order, with `tx_last` on the final one; at the handshake of that beat done (status bit 1) is set, busy (status bit 0) is cleared and the index becomes 0.
- R5: A buffered write start whose index differs from the count sets device error (status bit 2), makes the index 0 and sends no byte.
- R6: While device error is set a start is ignored: no transfer begins and the index keeps its value.
- R7: A block read stores incoming bytes from position 0, writes the number of bytes received (capped at 32, extra bytes dropped) into the count register and makes the index 0; in buffered mode done is set at once and busy stays set.
- R8: In buffered read mode the block-port read that takes the index up to the count ends the operation: index 0, busy cleared, operation-done flag set.
- R9: A byte-at-a-time write start sets busy and byte-done (status bit 7) and takes the holding register as byte 0; each status write then adds one to the index and, below the count, stores the holding register at the new index and sets byte-done; at the count the bytes are streamed out, then done is set and busy cleared.
- R10: A byte-at-a-time read presents byte 0 on the block port with busy and byte-done set; each status write presents the next byte and sets byte-done, or, with the last-byte flag high, presents it and sets done, clears busy and makes the index 0.
- R11: A byte-at-a-time write started with the I2C block-read protocol flag sets device error and clears busy when the count is reached, and sends nothing.
- R12: A status write clears each of bits 1, 2 and 7 written as 1 and never clears busy; a set of the same bit in the same cycle wins.
- R13: `tx_valid`, `tx_data` and `tx_last` stay stable while `tx_ready` is low; `rx_ready` is high only while a read is receiving; block-port writes during a transfer change neither the index nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_wr | input | 1 | Mode register write strobe |
| aux_wdata | input | 2 | Mode value (bit 1 buffered, bit 0 PEC enable) |
| aux_q | output | 2 | Mode register contents |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count value |
| cnt_q | output | 8 | Count register contents |
| blk_wr | input | 1 | Block data port write strobe |
| blk_wdata | input | 8 | Block data port write value |
| blk_rd | input | 1 | Block data port read strobe |
| blk_rdata | output | 8 | Block data port read value |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write value (ones clear) |
| sts_q | output | 8 | Status: bit 0 busy, 1 done, 2 device error, 7 byte-done |
| start | input | 1 | Start a block transaction |
| start_read | input | 1 | Direction of the started transaction, 1 = read |
| start_i2c_rd | input | 1 | I2C block-read protocol selected at start |
| ctl_last | input | 1 | Last-byte control flag |
| op_done | output | 1 | Operation-done flag |
| idx_q | output | 6 | Buffer index |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte accepted |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Incoming byte can be taken |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final incoming byte |

## Verification
The collision that matters is a status write that clears done arriving in the same cycle as the final outgoing handshake that sets done. The bench stalls the last beat of a buffered write, then raises `tx_ready` and a status write of 0x02 together, and expects done to read 1 with busy cleared afterwards. A second overlap, a block-port write issued while the outgoing stream is stalled, is judged by the index staying at 0 and the following beats still carrying the queued bytes.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2,
    ST_PB   = 2'd3
  } seq_state_e;

  localparam int STS_BUSY  = 0;
  localparam int STS_DONE  = 1;
  localparam int STS_DERR  = 2;
  localparam int STS_BDONE = 7;
endpackage

// File: rtl/smbblk_store.sv
module smbblk_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int NRD   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*$clog2(DEPTH)-1:0] raddr,
  output logic [NRD*DW-1:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*DW +: DW] = mem[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/smbblk_txq.sv
module smbblk_txq #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [CW-1:0]            len,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  input  logic [DW-1:0]            rd_data,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [DW-1:0]            tx_data,
  output logic                     tx_last,
  output logic                     fin
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 1;

  logic          active;
  logic [IW-1:0] ptr, lim;

  assign rd_addr  = ptr[AW-1:0];
  assign tx_valid = active;
  assign tx_data  = rd_data;
  assign tx_last  = active && ((ptr + IW'(1)) == lim);
  assign fin      = active && tx_ready && tx_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
      lim    <= '0;
    end else if (go) begin
      active <= 1'b1;
      ptr    <= '0;
      lim    <= (len > CW'(DEPTH)) ? IW'(DEPTH) : IW'(len);
    end else if (active && tx_ready) begin
      if (tx_last) active <= 1'b0;
      else         ptr    <= ptr + IW'(1);
    end
  end

  // R13: a stalled beat keeps its payload
  a_r13_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R4: the stream stops after the final handshake
  a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !tx_valid);
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import smbblk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       aux_wr,
  input  logic [1:0]                 aux_wdata,
  output logic [1:0]                 aux_q,
  input  logic                       cnt_wr,
  input  logic [DW-1:0]              cnt_wdata,
  output logic [DW-1:0]              cnt_q,
  input  logic                       blk_wr,
  input  logic [DW-1:0]              blk_wdata,
  input  logic                       blk_rd,
  output logic [DW-1:0]              blk_rdata,
  input  logic                       sts_wr,
  input  logic [7:0]                 sts_wdata,
  output logic [7:0]                 sts_q,
  input  logic                       start,
  input  logic                       start_read,
  input  logic                       start_i2c_rd,
  input  logic                       ctl_last,
  output logic                       op_done,
  output logic [$clog2(DEPTH):0]     idx_q,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [DW-1:0]              tx_data,
  output logic                       tx_last,
  input  logic                       rx_valid,
  output logic                       rx_ready,
  input  logic [DW-1:0]              rx_data,
  input  logic                       rx_last
);
  localparam int AW  = $clog2(DEPTH);
  localparam int IW  = AW + 1;
  localparam int CW  = DW;
  localparam int NRD = 3;

  seq_state_e    state;
  logic [IW-1:0] idx, rxk;
  logic [CW-1:0] cnt;
  logic [1:0]    aux;
  logic [DW-1:0] blk_reg;
  logic          st_busy, st_done, st_derr, st_bdone;
  logic          done_q, rd_dir, i2c_q;

  logic          buffered;
  logic [IW-1:0] idx_w, idx_inc, adv_n;
  logic          port_ok, blk_wr_q, blk_rd_q, start_ok, bw_match;
  logic          pb_adv, pb_end, rx_fire, rx_room, tx_go, tx_fin;

  logic          mem_we;
  logic [AW-1:0] mem_waddr, tx_addr;
  logic [DW-1:0] mem_wdata, rd_port, rd_next, tx_rd;
  logic [NRD*AW-1:0] mem_raddr;
  logic [NRD*DW-1:0] mem_rdata;

  assign buffered = aux[1];

  always_comb begin
    idx_w   = (idx >= IW'(DEPTH)) ? '0 : idx;
    idx_inc = idx_w + IW'(1);
    adv_n   = idx + IW'(1);
  end

  assign port_ok  = (state == ST_IDLE);
  assign blk_wr_q = blk_wr && buffered && port_ok;
  assign blk_rd_q = blk_rd && buffered && port_ok;
  assign start_ok = start && (state == ST_IDLE) && !st_busy && !st_derr;
  assign bw_match = (CW'(idx) == cnt);
  assign pb_adv   = sts_wr && !done_q && !buffered && (state == ST_PB);
  assign pb_end   = pb_adv && !rd_dir && (CW'(adv_n) == cnt);
  assign rx_fire  = rx_valid && (state == ST_RX);
  assign rx_room  = (rxk < IW'(DEPTH));
  assign tx_go    = (start_ok && !start_read && buffered && bw_match && (cnt != '0))
                 || (pb_end && !i2c_q);

  // single buffer write port, sources are exclusive by state
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = '0;
    mem_wdata = '0;
    if (rx_fire && rx_room) begin
      mem_we    = 1'b1;
      mem_waddr = rxk[AW-1:0];
      mem_wdata = rx_data;
    end else if (start_ok && !start_read && !buffered) begin
      mem_we    = 1'b1;
      mem_waddr = '0;
      mem_wdata = blk_reg;
    end else if (pb_adv && !rd_dir && !pb_end) begin
      mem_we    = 1'b1;
      mem_waddr = adv_n[AW-1:0];
      mem_wdata = blk_reg;
    end else if (blk_wr_q) begin
      mem_we    = 1'b1;
      mem_waddr = idx_w[AW-1:0];
      mem_wdata = blk_wdata;
    end
  end

  assign mem_raddr = {tx_addr, adv_n[AW-1:0], idx_w[AW-1:0]};
  assign rd_port   = mem_rdata[0*DW +: DW];
  assign rd_next   = mem_rdata[1*DW +: DW];
  assign tx_rd     = mem_rdata[2*DW +: DW];

  smbblk_store #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  smbblk_txq #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (tx_go),
    .len      (cnt),
    .rd_addr  (tx_addr),
    .rd_data  (tx_rd),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .fin      (tx_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      rxk      <= '0;
      cnt      <= '0;
      aux      <= '0;
      blk_reg  <= '0;
      st_busy  <= 1'b0;
      st_done  <= 1'b0;
      st_derr  <= 1'b0;
      st_bdone <= 1'b0;
      done_q   <= 1'b1;
      rd_dir   <= 1'b0;
      i2c_q    <= 1'b0;
    end else begin
      if (aux_wr) aux <= aux_wdata;
      if (cnt_wr) cnt <= cnt_wdata;
      if (blk_wr && !buffered) blk_reg <= blk_wdata;

      // clears first; any set below in the same cycle overrides
      if (sts_wr) begin
        if (sts_wdata[STS_DONE])  st_done  <= 1'b0;
        if (sts_wdata[STS_DERR])  st_derr  <= 1'b0;
        if (sts_wdata[STS_BDONE]) st_bdone <= 1'b0;
      end

      if (blk_wr_q) idx <= idx_inc;

      if (blk_rd_q) begin
        idx <= idx_inc;
        if (!done_q && (CW'(idx_inc) == cnt)) begin
          done_q  <= 1'b1;
          idx     <= '0;
          st_busy <= 1'b0;
        end
      end

      if (start_ok) begin
        rd_dir <= start_read;
        i2c_q  <= start_i2c_rd;
        idx    <= '0;
        if (start_read) begin
          state   <= ST_RX;
          st_busy <= 1'b1;
          rxk     <= '0;
        end else if (buffered) begin
          if (!bw_match)        st_derr <= 1'b1;
          else if (cnt == '0)   st_done <= 1'b1;
          else begin
            state   <= ST_TX;
            st_busy <= 1'b1;
          end
        end else begin
          state    <= ST_PB;
          done_q   <= 1'b0;
          st_busy  <= 1'b1;
          st_bdone <= 1'b1;
        end
      end

      if (pb_adv) begin
        if (!rd_dir) begin
          idx <= adv_n;
          if (pb_end) begin
            done_q <= 1'b1;
            if (i2c_q) begin
              st_derr <= 1'b1;
              st_busy <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              state <= ST_TX;
            end
          end else begin
            st_bdone <= 1'b1;
          end
        end else begin
          blk_reg <= rd_next;
          if (ctl_last) begin
            done_q  <= 1'b1;
            idx     <= '0;
            st_done <= 1'b1;
            st_busy <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            idx      <= adv_n;
            st_bdone <= 1'b1;
          end
        end
      end

      if (rx_fire) begin
        if (rx_room) rxk <= rxk + IW'(1);
        if ((rxk == '0) && !buffered) blk_reg <= rx_data;
        if (rx_last) begin
          cnt    <= rx_room ? (CW'(rxk) + CW'(1)) : CW'(DEPTH);
          idx    <= '0;
          done_q <= 1'b0;
          if (buffered) begin
            st_done <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            st_bdone <= 1'b1;
            state    <= ST_PB;
          end
        end
      end

      if (tx_fin) begin
        st_done <= 1'b1;
        st_busy <= 1'b0;
        done_q  <= 1'b1;
        idx     <= '0;
        state   <= ST_IDLE;
      end
    end
  end

  assign aux_q     = aux;
  assign cnt_q     = cnt;
  assign idx_q     = idx;
  assign op_done   = done_q;
  assign rx_ready  = (state == ST_RX);
  assign blk_rdata = buffered ? rd_port : blk_reg;
  assign sts_q     = {st_bdone, 4'b0000, st_derr, st_done, st_busy};

  // R5: count mismatch refuses the transfer
  a_r5_count_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && !start_read && buffered && !bw_match |=> st_derr && (idx == '0) && !tx_valid);

  // R6: pending device error blocks a start
  a_r6_err_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && st_derr && (state == ST_IDLE) |=> !tx_valid && !rx_ready);

  // R8: draining to the count ends the buffered read
  a_r8_drain_done: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rd_q && !done_q && (CW'(idx_inc) == cnt) |=> done_q && (idx == '0) && !st_busy);

  // R9: a mid-message status write advances and flags byte-done
  a_r9_pb_advance: assert property (@(posedge clk) disable iff (!rst_n)
    pb_adv && !rd_dir && !pb_end |=> st_bdone && (idx == $past(adv_n)));

  // R12: the completion set wins over a same-cycle clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fin |=> st_done && !st_busy);

  // R13: no outgoing beat outside a transfer
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !tx_valid);
endmodule

// File: tb/smb_blkbuf_bench.sv
module smb_blkbuf_bench;
  localparam int DEPTH = 32;
  localparam int DW    = 8;
  localparam logic [15:0] VEC [6] = '{16'h0110, 16'h0533, 16'h2001,
                                      16'h03F0, 16'h107A, 16'h0200};

  logic clk = 1'b0;
  logic rst_n;
  logic aux_wr, cnt_wr, blk_wr, blk_rd, sts_wr, start, start_read, start_i2c_rd, ctl_last;
  logic [1:0] aux_wdata, aux_q;
  logic [7:0] cnt_wdata, cnt_q, blk_wdata, blk_rdata, sts_wdata, sts_q;
  logic op_done;
  logic [5:0] idx_q;
  logic tx_valid, tx_ready, tx_last, rx_valid, rx_ready, rx_last;
  logic [7:0] tx_data, rx_data;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] model [64];

  always #4 clk = ~clk;

  smb_blkbuf #(.DEPTH(DEPTH), .DW(DW)) u_smb_blkbuf (
    .clk(clk), .rst_n(rst_n),
    .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_q(aux_q),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .blk_rd(blk_rd), .blk_rdata(blk_rdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_q(sts_q),
    .start(start), .start_read(start_read), .start_i2c_rd(start_i2c_rd),
    .ctl_last(ctl_last), .op_done(op_done), .idx_q(idx_q),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_aux(input logic [1:0] v);
    aux_wr = 1'b1; aux_wdata = v; cyc(); aux_wr = 1'b0;
  endtask
  task automatic wr_cnt(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; cyc(); cnt_wr = 1'b0;
  endtask
  task automatic wr_blk(input logic [7:0] v);
    blk_wr = 1'b1; blk_wdata = v; cyc(); blk_wr = 1'b0;
  endtask
  task automatic rd_blk(output logic [7:0] v);
    v = blk_rdata; blk_rd = 1'b1; cyc(); blk_rd = 1'b0;
  endtask
  task automatic wr_sts(input logic [7:0] v);
    sts_wr = 1'b1; sts_wdata = v; cyc(); sts_wr = 1'b0;
  endtask
  task automatic do_start(input logic rd, input logic i2c);
    start = 1'b1; start_read = rd; start_i2c_rd = i2c; cyc();
    start = 1'b0; start_read = 1'b0; start_i2c_rd = 1'b0;
  endtask

  task automatic collect(input int n, input bit stall);
    logic [7:0] d0;
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      while (!tx_valid && guard < 50) begin cyc(); guard++; end
      if (stall) begin
        d0 = tx_data;
        cyc();
        chk("R13 tx held under stall", {tx_valid, tx_data}, {1'b1, d0});
      end
      chk("R4 tx byte", tx_data, model[i]);
      chk("R4 tx last flag", tx_last, (i == n - 1));
      tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
    end
  endtask

  task automatic send_rx(input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = model[i]; rx_last = (i == n - 1);
      cyc();
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] got;
    rst_n = 1'b0;
    {aux_wr, cnt_wr, blk_wr, blk_rd, sts_wr, start, start_read, start_i2c_rd, ctl_last} = '0;
    aux_wdata = '0; cnt_wdata = '0; blk_wdata = '0; sts_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 status", sts_q, 8'h00);
    chk("R1 op_done", op_done, 1);
    chk("R1 index", idx_q, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R13 rx_ready idle", rx_ready, 0);

    // R2 mode register
    wr_aux(2'b01);
    chk("R2 pec bit", aux_q, 2'b01);
    wr_aux(2'b11);
    chk("R2 both bits", aux_q, 2'b11);

    // table walk: buffered write then buffered read per entry
    for (int v = 0; v < 6; v++) begin
      int len;
      logic [7:0] seed;
      len  = int'(VEC[v][15:8]);
      seed = VEC[v][7:0];
      wr_aux(2'b10);
      wr_sts(8'h86);
      for (int i = 0; i < len; i++) begin
        model[i] = seed + 8'(7 * i);
        wr_blk(model[i]);
      end
      chk("R3 index after fill", idx_q, len);
      wr_cnt(8'(len));
      do_start(1'b0, 1'b0);
      collect(len, v[0]);
      chk("R4 status after send", sts_q, 8'h02);
      chk("R4 index after send", idx_q, 0);
      do_start(1'b1, 1'b0);
      chk("R13 rx_ready receiving", rx_ready, 1);
      for (int i = 0; i < len; i++) model[i] = ~seed ^ 8'(i);
      send_rx(len);
      chk("R7 count from read", cnt_q, len);
      chk("R7 done and busy", sts_q, 8'h03);
      for (int i = 0; i < len; i++) begin
        rd_blk(got);
        chk("R3 drained byte", got, model[i]);
      end
      chk("R8 busy cleared", sts_q, 8'h02);
      chk("R8 index zero", idx_q, 0);
      chk("R8 op_done", op_done, 1);
    end

    // R3 wrap at capacity
    for (int i = 0; i < DEPTH; i++) wr_blk(8'h40 + 8'(i));
    chk("R3 index at capacity", idx_q, 32);
    wr_blk(8'hC5);
    chk("R3 index after wrap", idx_q, 1);
    wr_cnt(8'd1);
    model[0] = 8'hC5;
    do_start(1'b0, 1'b0);
    collect(1, 1'b0);

    // R5 count mismatch
    wr_sts(8'h86);
    for (int i = 0; i < 3; i++) wr_blk(8'h11 * 8'(i + 1));
    wr_cnt(8'd4);
    do_start(1'b0, 1'b0);
    chk("R5 device error", sts_q, 8'h04);
    chk("R5 index reset", idx_q, 0);
    cyc(); cyc();
    chk("R5 nothing sent", tx_valid, 0);

    // R6 start ignored while error pending
    for (int i = 0; i < 4; i++) begin
      model[i] = 8'hA0 + 8'(i);
      wr_blk(model[i]);
    end
    do_start(1'b0, 1'b0);
    cyc();
    chk("R6 no transfer", tx_valid, 0);
    chk("R6 index kept", idx_q, 4);
    wr_sts(8'h04);
    chk("R12 error cleared", sts_q, 8'h00);
    do_start(1'b0, 1'b0);
    collect(4, 1'b0);

    // R12 busy survives status writes
    do_start(1'b1, 1'b0);
    model[0] = 8'h5A; model[1] = 8'hA5;
    send_rx(2);
    wr_sts(8'h01);
    chk("R12 busy not cleared", sts_q, 8'h03);
    wr_sts(8'h83);
    chk("R12 done cleared busy kept", sts_q, 8'h01);
    rd_blk(got); rd_blk(got);
    chk("R8 drained", sts_q, 8'h00);

    // R12 same-cycle set and clear, R13 port write during transfer
    model[0] = 8'h3C; model[1] = 8'hC3;
    wr_blk(model[0]); wr_blk(model[1]);
    wr_cnt(8'd2);
    do_start(1'b0, 1'b0);
    wr_blk(8'hEE);
    chk("R13 index frozen in transfer", idx_q, 0);
    chk("R13 queued byte kept", tx_data, 8'h3C);
    tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
    chk("R13 second byte kept", tx_data, 8'hC3);
    chk("R4 last on second", tx_last, 1);
    tx_ready = 1'b1; sts_wr = 1'b1; sts_wdata = 8'h02;
    cyc();
    tx_ready = 1'b0; sts_wr = 1'b0;
    chk("R12 set wins over clear", sts_q, 8'h02);

    // R9 byte-at-a-time write
    wr_aux(2'b00);
    wr_sts(8'h86);
    wr_cnt(8'd3);
    model[0] = 8'hD0; model[1] = 8'hD1; model[2] = 8'hD2;
    wr_blk(model[0]);
    do_start(1'b0, 1'b0);
    chk("R9 start status", sts_q, 8'h81);
    chk("R9 op_done low", op_done, 0);
    wr_blk(model[1]);
    wr_sts(8'h80);
    chk("R9 byte-done again", sts_q, 8'h81);
    chk("R9 index 1", idx_q, 1);
    wr_blk(model[2]);
    wr_sts(8'h80);
    chk("R9 index 2", idx_q, 2);
    wr_sts(8'h80);
    collect(3, 1'b1);
    chk("R9 finished status", sts_q, 8'h02);

    // R11 protocol flag turns completion into an error
    wr_sts(8'h86);
    wr_cnt(8'd1);
    wr_blk(8'hB7);
    do_start(1'b0, 1'b1);
    wr_sts(8'h80);
    chk("R11 error status", sts_q, 8'h04);
    cyc(); cyc();
    chk("R11 nothing sent", tx_valid, 0);
    wr_sts(8'h04);

    // R10 byte-at-a-time read
    ctl_last = 1'b0;
    do_start(1'b1, 1'b0);
    model[0] = 8'hE1; model[1] = 8'hE2; model[2] = 8'hE3;
    send_rx(3);
    chk("R10 count", cnt_q, 3);
    chk("R10 first byte", blk_rdata, 8'hE1);
    chk("R10 first status", sts_q, 8'h81);
    wr_sts(8'h80);
    chk("R10 second byte", blk_rdata, 8'hE2);
    chk("R10 index 1", idx_q, 1);
    chk("R10 byte-done", sts_q, 8'h81);
    ctl_last = 1'b1;
    wr_sts(8'h80);
    ctl_last = 1'b0;
    chk("R10 last byte", blk_rdata, 8'hE3);
    chk("R10 final status", sts_q, 8'h02);
    chk("R10 index reset", idx_q, 0);
    chk("R10 op_done", op_done, 1);

    // R7 oversize read is capped
    wr_aux(2'b10);
    do_start(1'b1, 1'b0);
    for (int i = 0; i < 34; i++) model[i] = 8'h60 + 8'(i);
    send_rx(34);
    chk("R7 capped count", cnt_q, 32);
    for (int i = 0; i < DEPTH; i++) begin
      rd_blk(got);
      if (i == 0 || i == DEPTH - 1) chk("R7 capped data", got, model[i]);
    end
    chk("R8 capped drain", sts_q, 8'h02);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule